// File: doc/BRIEF.md
# Glitch-Filtered Edge Interrupt Request Unit

This unit turns one asynchronous external pin into a clean interrupt request. The pin passes through a two-flop synchronizer. A new synchronized level becomes the accepted level only after it has held for a programmed number of consecutive clock cycles, so narrow pulses are discarded. When the accepted level reaches the polarity selected in a 4-bit control register, a sticky request flag is set. The flag drives the interrupt output through a local enable and a global enable.

Software can consume the request in two ways. The interrupt can be taken, which is signalled by an acknowledge pulse. Or a poll strobe can sample the flag: it reports a skip when the flag is set, and that consumes the flag. The control register also holds a prescaler ratio select and two key-wakeup enables. These bits are only stored here and driven out to neighbouring logic. A retain input keeps the register contents through a reset, which models a low-power hold state.

Top module: `edge_irq_filter`

## Requirements
- R1: After the 2-flop synchronizer, a pin level that differs from the accepted level becomes the new accepted level only after it has been sampled for STABLE_CYCLES (default 5) consecutive clock cycles. A pulse lasting 4 cycles never sets the flag. A pulse lasting 5 cycles is accepted.
- R2: Control bit 2 (`edge_falling`) selects the polarity. When it is 0, a low-to-high change of the accepted level is a valid edge. When it is 1, a high-to-low change is a valid edge. A change in the other direction has no effect.
- R3: A valid edge sets the request flag in the clock cycle after the accepted level changes.
- R4: A cycle with `int_ack` high clears the flag at that clock edge.
- R5: `skip_taken` equals `skip_strobe` AND the flag, combinationally. When it is high, the flag clears at that clock edge. A strobe while the flag is clear reports 0.
- R6: `irq` is high exactly when the flag, `int_en` and `glob_en` are all 1.
- R7: While `rst_n` is low and `retain` is low, the control register becomes 0000. While `retain` is high, reset leaves the register unchanged. While `rst_n` is high, `reg_we` loads `reg_wdata`, and `reg_rdata` always shows the current register value.
- R8: The outputs export the control bits as follows: `presc_div512` is bit 3, `edge_falling` is bit 2, `wake_b_en` is bit 1 and `wake_a_en` is bit 0.
- R9: Writing a new polarity whose target level equals the current accepted level sets the flag one cycle after the write.
- R10: When a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| retain | input | 1 | Keeps the control register through reset |
| pin_async | input | 1 | Asynchronous external interrupt pin |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 4 | Control register write data |
| reg_rdata | output | 4 | Current control register value |
| int_en | input | 1 | Local external-interrupt enable |
| glob_en | input | 1 | Global interrupt enable |
| int_ack | input | 1 | Interrupt taken; clears the flag |
| skip_strobe | input | 1 | Poll-and-skip test of the flag |
| skip_taken | output | 1 | Poll result; flag was set |
| irq | output | 1 | Gated interrupt request |
| presc_div512 | output | 1 | Prescaler ratio select (1: /512, 0: /4) |
| edge_falling | output | 1 | Selected polarity |
| wake_b_en | output | 1 | Key-wakeup enable, port group B |
| wake_a_en | output | 1 | Key-wakeup enable, port group A |

## Verification
A set and a clear can land on the same clock edge. The set comes from a newly accepted edge or from a polarity write. The clear comes from an acknowledge or a successful poll. The bench provokes this collision by holding `int_ack` high through the whole filter window while the pin changes. The set must win, so `irq` must then be high for exactly one cycle. A behavioural model compares every output against the design on every clock, through the whole run and through that collision.

// File: rtl/edge_irq_filter.sv
module edge_irq_filter #(
  parameter int STABLE_CYCLES = 5,
  parameter int SYNC_STAGES   = 2,
  parameter int CTRL_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retain,
  input  logic              pin_async,
  input  logic              reg_we,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic              int_en,
  input  logic              glob_en,
  input  logic              int_ack,
  input  logic              skip_strobe,
  output logic              skip_taken,
  output logic              irq,
  output logic              presc_div512,
  output logic              edge_falling,
  output logic              wake_b_en,
  output logic              wake_a_en
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] RUN_LAST = CW'(STABLE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_cnt;
  logic                   filt_lvl, prev_hit, flag;
  logic [CTRL_W-1:0]      ctrl;

  wire sync_lvl = sync_q[SYNC_STAGES-1];
  wire at_tgt   = (filt_lvl != ctrl[2]);
  wire edge_ev  = at_tgt & ~prev_hit;
  wire clr_ev   = int_ack | skip_taken;

  assign skip_taken   = skip_strobe & flag;
  assign irq          = flag & int_en & glob_en;
  assign reg_rdata    = ctrl;
  assign presc_div512 = ctrl[3];
  assign edge_falling = ctrl[2];
  assign wake_b_en    = ctrl[1];
  assign wake_a_en    = ctrl[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= '0;
      run_cnt  <= '0;
      filt_lvl <= 1'b0;
      prev_hit <= 1'b1;
      flag     <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], pin_async};
      prev_hit <= at_tgt;
      if (edge_ev)     flag <= 1'b1;
      else if (clr_ev) flag <= 1'b0;
      if (sync_lvl == filt_lvl) begin
        run_cnt <= '0;
      end else if (run_cnt == RUN_LAST) begin
        run_cnt  <= '0;
        filt_lvl <= sync_lvl;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (!retain) ctrl <= '0;
    end else if (reg_we) begin
      ctrl <= reg_wdata;
    end
  end

  a_r1_filter_window: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_lvl) |-> $past(run_cnt) == RUN_LAST);
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !edge_ev) |=> !flag);
  a_r5_skip_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_taken && !edge_ev) |=> !flag);
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    edge_ev |=> flag);
  a_r3_flag_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(edge_ev));
endmodule

// File: tb/edge_irq_filter_test.sv
module edge_irq_filter_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, retain = 0, pin_async = 0, reg_we = 0;
  logic [3:0] reg_wdata = 0, reg_rdata;
  logic int_en = 0, glob_en = 0, int_ack = 0, skip_strobe = 0;
  logic skip_taken, irq, presc_div512, edge_falling, wake_b_en, wake_a_en;

  int n_run = 0, n_fail = 0;
  bit started = 0;

  edge_irq_filter uut (.*);

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference
  int m_q[$] = '{0, 0};
  int m_filt = 0, m_run = 0, m_prev = 1, m_flag = 0;
  logic [3:0] m_ctrl = 0;

  always @(posedge clk) begin
    int tgt, hit, setv, clrv, lvl;
    if (!rst_n) begin
      m_q = '{0, 0}; m_filt = 0; m_run = 0; m_prev = 1; m_flag = 0;
      if (!retain) m_ctrl = 0;
    end else begin
      tgt  = m_ctrl[2] ? 0 : 1;
      hit  = (m_filt == tgt);
      setv = hit && !m_prev;
      clrv = int_ack || (skip_strobe && m_flag);
      if (setv) m_flag = 1; else if (clrv) m_flag = 0;
      m_prev = hit;
      lvl = m_q[0];
      if (lvl != m_filt) begin
        if (m_run == 4) begin m_filt = lvl; m_run = 0; end
        else m_run++;
      end else m_run = 0;
      void'(m_q.pop_front());
      m_q.push_back(int'(pin_async));
      if (reg_we) m_ctrl = reg_wdata;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (started) begin
      chk("R6 irq vs model", irq, m_flag & int_en & glob_en);
      chk("R5 skip vs model", skip_taken, skip_strobe & m_flag);
      chk("R7 rdata vs model", reg_rdata, m_ctrl);
      chk("R8 exports vs model", {presc_div512, edge_falling, wake_b_en, wake_a_en}, m_ctrl);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [3:0] v);
    reg_wdata = v; reg_we = 1; step(); reg_we = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int pulses;
    step(3);
    started = 1;
    chk("R7 reset value", reg_rdata, 0);
    chk("R6 reset irq", irq, 0);
    rst_n = 1;
    wr(4'b0000);
    int_en = 1; glob_en = 1;

    pin_async = 1; step(12);
    chk("R3 rising edge sets", irq, 1);
    int_ack = 1; step(); int_ack = 0; step(); #1;
    chk("R4 ack clears", irq, 0);

    pin_async = 0; step(12);
    chk("R2 falling ignored in rising mode", irq, 0);

    pin_async = 1; step(4); pin_async = 0; step(12);
    chk("R1 4-cycle pulse rejected", irq, 0);
    pin_async = 1; step(5); pin_async = 0; step(12);
    chk("R1 5-cycle pulse accepted", irq, 1);

    skip_strobe = 1; #1;
    chk("R5 poll reports skip", skip_taken, 1);
    step(); #1;
    chk("R5 poll after consume", skip_taken, 0);
    skip_strobe = 0; step();

    wr(4'b0100); step(2); #1;
    chk("R9 polarity write spurious set", irq, 1);
    chk("R8 edge_falling export", edge_falling, 1);
    int_ack = 1; step(); int_ack = 0;

    wr(4'b0000); step(3);
    chk("R9 no set when target differs", irq, 0);
    pin_async = 1; step(12);
    chk("R3 set again", irq, 1);
    glob_en = 0; #1; chk("R6 global gate", irq, 0);
    glob_en = 1; int_en = 0; #1; chk("R6 local gate", irq, 0);
    int_en = 1; #1; chk("R6 both on", irq, 1);
    int_ack = 1; step(); int_ack = 0; step();

    wr(4'b0100); step(3);
    chk("R2 rising ignored in falling mode", irq, 0);
    int_ack = 1; pin_async = 0; pulses = 0;
    for (int i = 0; i < 14; i++) begin step(); #1; if (irq) pulses++; end
    int_ack = 0;
    chk("R10 set wins over ack", pulses, 1);
    step();

    wr(4'b1011); #1;
    chk("R7 readback", reg_rdata, 4'b1011);
    chk("R8 exports", {presc_div512, edge_falling, wake_b_en, wake_a_en}, 4'b1011);

    retain = 1; rst_n = 0; step(2); #1;
    chk("R7 retain holds ctrl", reg_rdata, 4'b1011);
    retain = 0; step(2); #1;
    chk("R7 reset clears ctrl", reg_rdata, 0);
    rst_n = 1; step(3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule